// File: doc/BRIEF.md
# Serial Peripheral FIFO Status and Interrupt Unit

This unit holds the receive and transmit word queues of a serial peripheral, each four words deep, and turns their state into status flags and one interrupt line. The serial shift engine and the register decoder are not part of it. They reach the unit only as strobes: a word pushed into the receive queue, a word pulled from the transmit queue, a transmit-empty event at shift time, and a write-1-to-clear vector.

Two status flags follow the queue occupancy level by level, compared against two 2-bit threshold inputs. Three status flags are sticky: receive overrun, receive timeout and slave transmit underrun. The timeout window is 64 clocks when the peripheral is the master and 576 clocks when it is a slave. An underflow seen during a slave transfer is held in a pending bit. It becomes visible only when slave select goes inactive. Each flag has an enable bit, and the interrupt is the OR of the enabled flags.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each queue returns words in the order they were pushed. The oldest word is shown on the read-data output while the queue is not empty, and the count outputs give the number of stored words (0 to 4).
- R2: A push to a queue holding 4 words is dropped, and a pop from an empty queue is ignored. Neither changes the count or the stored words. A push and a pop in the same cycle on a non-full, non-empty queue leave the count unchanged.
- R3: `rx_full` is 1 exactly when the receive queue holds 4 words.
- R4: In slave mode, a receive push while the receive queue holds 4 words sets `ovr_flag` one cycle later, and that word is discarded, even when a pop happens in the same cycle. In master mode the same push is dropped without setting the flag.
- R5: In master mode, `tmo_flag` is set at the 64th consecutive clock edge at which the receive queue was not empty and no pop occurred.
- R6: In slave mode the timeout limit of R5 is 576 edges. A pop, or an empty receive queue, at an edge restarts the count from zero.
- R7: `txth_flag` is 1 whenever the transmit count is less than or equal to `tx_thresh`.
- R8: `rxth_flag` is 1 whenever the receive count is strictly greater than `rx_thresh`.
- R9: A `tx_underflow` pulse while `slave_mode` and `ss_active` are both 1 is held pending. `udr_flag` is set at the edge that samples `ss_active` going from 1 to 0, and only if an underflow is pending. The pending state is then cleared.
- R10: `ovr_flag`, `tmo_flag` and `udr_flag` stay at 1 until cleared by `flag_clr` bit 0, 1 or 2 respectively. If a set and a clear fall in the same cycle, the set wins.
- R11: `irq` is the OR of the five flags, each gated by its bit of `irq_en`: bit 0 txth, bit 1 rxth, bit 2 overrun, bit 3 timeout, bit 4 underrun.
- R12: After reset both counts are 0 and the three sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| ss_active | input | 1 | Slave select is asserted |
| rx_push | input | 1 | Receive word arrives from the shifter |
| rx_wdata | input | 8 | Received word |
| rx_pop | input | 1 | Software reads the receive queue |
| rx_rdata | output | 8 | Oldest receive word |
| rx_count | output | 3 | Receive queue occupancy |
| rx_full | output | 1 | Receive queue holds 4 words |
| tx_push | input | 1 | Software writes the transmit queue |
| tx_wdata | input | 8 | Transmit word |
| tx_pop | input | 1 | Shifter takes a transmit word |
| tx_rdata | output | 8 | Oldest transmit word |
| tx_count | output | 3 | Transmit queue occupancy |
| tx_underflow | input | 1 | Transmit queue was empty when the shifter needed a word |
| tx_thresh | input | 2 | Transmit threshold |
| rx_thresh | input | 2 | Receive threshold |
| irq_en | input | 5 | Per-flag interrupt enables |
| flag_clr | input | 3 | Write-1-to-clear: bit 0 overrun, bit 1 timeout, bit 2 underrun |
| txth_flag | output | 1 | Transmit level at or below threshold |
| rxth_flag | output | 1 | Receive level above threshold |
| ovr_flag | output | 1 | Sticky receive overrun |
| tmo_flag | output | 1 | Sticky receive timeout |
| udr_flag | output | 1 | Sticky slave transmit underrun |
| irq | output | 1 | Combined interrupt |

## Verification
Two cases can fall in the same cycle and need care. In the first, an overrun set coincides with a write-1-to-clear of the same flag. The bench provokes this by pushing into a full receive queue in slave mode while pulsing the clear bit, and expects the flag to read 1 afterwards. In the second, a push to a full receive queue coincides with a pop. The expected result is a count of 3, with the pushed word absent from the later read order. A behavioural model built on queues and integer counters tracks every flag and the queue contents, and it is compared against the outputs on every clock, including the exact edge at which each timeout window expires.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int FLAG_N = 5;

  // Bit order matches the irq_en port: txth is bit 0, udr is bit 4
  typedef struct packed {
    logic udr;
    logic tmo;
    logic ovr;
    logic rxth;
    logic txth;
  } flag_vec_t;
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, wptr_n, rptr, rptr_n;
  logic [CW-1:0]    count_n;
  logic             full, empty, push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr];

  always_comb begin
    wptr_n  = push_ok ? ptr_inc(wptr) : wptr;
    rptr_n  = pop_ok  ? ptr_inc(rptr) : rptr;
    count_n = count + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end

  // Storage has no reset: only the pointers qualify its contents
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push_ok && (wptr == PW'(g))) mem[g] <= wdata;
      end
    end
  endgenerate

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/sfi_rx_timeout.sv
module sfi_rx_timeout #(
  parameter int MST_LIM = 64,
  parameter int SLV_LIM = 576,
  localparam int MAXL = (SLV_LIM > MST_LIM) ? SLV_LIM : MST_LIM,
  localparam int TW = $clog2(MAXL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic nonempty,
  input  logic pop,
  output logic hit
);
  logic [TW-1:0] cnt, cnt_n, cnt_inc, limit;
  logic          run;

  assign limit = slave ? TW'(SLV_LIM) : TW'(MST_LIM);
  assign run   = nonempty && !pop;

  always_comb begin
    cnt_inc = (cnt == TW'(MAXL)) ? cnt : cnt + 1'b1;
    cnt_n   = run ? cnt_inc : '0;
    hit     = run && (cnt_inc >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R6
  tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || !nonempty) |=> (cnt == '0));
endmodule

// File: rtl/sfi_underrun.sv
module sfi_underrun (
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic ss_active,
  input  logic tx_underflow,
  output logic post
);
  logic ss_q, pend, pend_n, ss_fall;

  assign ss_fall = ss_q && !ss_active;
  assign post    = ss_fall && pend;

  always_comb begin
    if (ss_fall) pend_n = 1'b0;
    else         pend_n = pend || (tx_underflow && slave && ss_active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      ss_q <= ss_active;
      pend <= pend_n;
    end
  end

  // R9
  udr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post |-> ($past(ss_active) && !ss_active));
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit #(
  parameter int DEPTH   = 4,
  parameter int WIDTH   = 8,
  parameter int TH_W    = 2,
  parameter int MST_LIM = 64,
  parameter int SLV_LIM = 576,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FN = sfi_pkg::FLAG_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic             ss_active,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [CW-1:0]    rx_count,
  output logic             rx_full,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [CW-1:0]    tx_count,
  input  logic             tx_underflow,
  input  logic [TH_W-1:0]  tx_thresh,
  input  logic [TH_W-1:0]  rx_thresh,
  input  logic [FN-1:0]    irq_en,
  input  logic [2:0]       flag_clr,
  output logic             txth_flag,
  output logic             rxth_flag,
  output logic             ovr_flag,
  output logic             tmo_flag,
  output logic             udr_flag,
  output logic             irq
);
  import sfi_pkg::*;

  flag_vec_t flags;
  logic      ovr_set, tmo_hit, udr_post;
  logic      ovr_n, tmo_n, udr_n;

  sfi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
    .pop(rx_pop), .rdata(rx_rdata), .count(rx_count));

  sfi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_rdata), .count(tx_count));

  sfi_rx_timeout #(.MST_LIM(MST_LIM), .SLV_LIM(SLV_LIM)) u_tmo (
    .clk(clk), .rst_n(rst_n), .slave(slave_mode),
    .nonempty(rx_count != '0), .pop(rx_pop), .hit(tmo_hit));

  sfi_underrun u_udr (
    .clk(clk), .rst_n(rst_n), .slave(slave_mode), .ss_active(ss_active),
    .tx_underflow(tx_underflow), .post(udr_post));

  assign rx_full   = (rx_count == CW'(DEPTH));
  assign ovr_set   = slave_mode && rx_push && rx_full;
  assign txth_flag = (tx_count <= CW'(tx_thresh));
  assign rxth_flag = (rx_count >  CW'(rx_thresh));

  // Sticky flags: a set in the same cycle overrides the clear
  always_comb begin
    ovr_n = ovr_set  || (ovr_flag && !flag_clr[0]);
    tmo_n = tmo_hit  || (tmo_flag && !flag_clr[1]);
    udr_n = udr_post || (udr_flag && !flag_clr[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      tmo_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else begin
      ovr_flag <= ovr_n;
      tmo_flag <= tmo_n;
      udr_flag <= udr_n;
    end
  end

  always_comb begin
    flags.txth = txth_flag;
    flags.rxth = rxth_flag;
    flags.ovr  = ovr_flag;
    flags.tmo  = tmo_flag;
    flags.udr  = udr_flag;
    irq        = |(flags & irq_en);
  end

  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && rx_push && rx_count == CW'(DEPTH)) |=> ovr_flag);
  // R5
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> ($past(rx_count) != '0));
  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !(slave_mode && rx_push && rx_count == CW'(DEPTH))) |=> !ovr_flag);
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);
endmodule

// File: tb/spi_fifo_irq_unit_bench.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       slave_mode, ss_active, rx_push, rx_pop, tx_push, tx_pop, tx_underflow;
  logic [7:0] rx_wdata, tx_wdata, rx_rdata, tx_rdata;
  logic [2:0] rx_count, tx_count, flag_clr;
  logic [1:0] tx_thresh, rx_thresh;
  logic [4:0] irq_en;
  logic       rx_full, txth_flag, rxth_flag, ovr_flag, tmo_flag, udr_flag, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit u_spi_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .ss_active(ss_active),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_full(rx_full), .tx_push(tx_push), .tx_wdata(tx_wdata),
    .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_count(tx_count),
    .tx_underflow(tx_underflow), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .irq_en(irq_en), .flag_clr(flag_clr), .txth_flag(txth_flag),
    .rxth_flag(rxth_flag), .ovr_flag(ovr_flag), .tmo_flag(tmo_flag),
    .udr_flag(udr_flag), .irq(irq));

  // Behavioural reference model
  logic [7:0] rxq[$], txq[$];
  int  idle;
  bit  m_ovr, m_tmo, m_udr, m_pend, m_ssp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      idle = 0; m_ovr = 0; m_tmo = 0; m_udr = 0; m_pend = 0; m_ssp = 0;
    end else begin
      int rxn, txn, lim;
      bit oset, tset, uset;
      rxn = rxq.size(); txn = txq.size();
      lim = slave_mode ? 576 : 64;
      oset = slave_mode && rx_push && (rxn == 4);
      if (rxn != 0 && !rx_pop) idle = (idle < 1000) ? idle + 1 : idle;
      else idle = 0;
      tset = (idle >= lim);
      uset = 0;
      if (m_ssp && !ss_active) begin uset = m_pend; m_pend = 0; end
      else if (tx_underflow && slave_mode && ss_active) m_pend = 1;
      m_ssp = ss_active;
      if (rx_pop && rxn > 0) void'(rxq.pop_front());
      if (rx_push && rxn < 4) rxq.push_back(rx_wdata);
      if (tx_pop && txn > 0) void'(txq.pop_front());
      if (tx_push && txn < 4) txq.push_back(tx_wdata);
      m_ovr = oset || (m_ovr && !flag_clr[0]);
      m_tmo = tset || (m_tmo && !flag_clr[1]);
      m_udr = uset || (m_udr && !flag_clr[2]);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_tx, e_rx, e_irq;
    e_tx  = (txq.size() <= int'(tx_thresh));
    e_rx  = (rxq.size() >  int'(rx_thresh));
    e_irq = (irq_en[0] && e_tx) || (irq_en[1] && e_rx) || (irq_en[2] && m_ovr) ||
            (irq_en[3] && m_tmo) || (irq_en[4] && m_udr);
    chk(int'(rx_count) == rxq.size(), "R1 R2", "rx_count", rx_count, rxq.size());
    chk(int'(tx_count) == txq.size(), "R1 R2", "tx_count", tx_count, txq.size());
    if (rxq.size() > 0) chk(rx_rdata == rxq[0], "R1", "rx_rdata", rx_rdata, rxq[0]);
    if (txq.size() > 0) chk(tx_rdata == txq[0], "R1", "tx_rdata", tx_rdata, txq[0]);
    chk(rx_full == (rxq.size() == 4), "R3", "rx_full", rx_full, rxq.size() == 4);
    chk(ovr_flag == m_ovr, "R4 R10", "ovr_flag", ovr_flag, m_ovr);
    chk(tmo_flag == m_tmo, "R5 R6", "tmo_flag", tmo_flag, m_tmo);
    chk(txth_flag == e_tx, "R7", "txth_flag", txth_flag, e_tx);
    chk(rxth_flag == e_rx, "R8", "rxth_flag", rxth_flag, e_rx);
    chk(udr_flag == m_udr, "R9", "udr_flag", udr_flag, m_udr);
    chk(irq == e_irq, "R11", "irq", irq, e_irq);
  endtask

  // One clock: inputs set at the negedge before, checked at the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    tx_underflow = 0; flag_clr = '0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    rst_n = 0; slave_mode = 0; ss_active = 0; rx_push = 0; rx_pop = 0;
    tx_push = 0; tx_pop = 0; tx_underflow = 0; rx_wdata = '0; tx_wdata = '0;
    tx_thresh = 2'd1; rx_thresh = 2'd1; irq_en = '0; flag_clr = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(rx_count == 0 && tx_count == 0, "R12", "counts", rx_count + tx_count, 0);
    chk(!ovr_flag && !tmo_flag && !udr_flag, "R12", "sticky", ovr_flag + tmo_flag + udr_flag, 0);
    rst_n = 1;
    idle_n(2);

    // Master: five pushes, fifth dropped without overrun (R2, R4)
    for (int i = 0; i < 5; i++) begin rx_push = 1; rx_wdata = 8'h10 + 8'(i); tick(); end
    chk(ovr_flag == 0, "R4", "master overrun", ovr_flag, 0);
    for (int t = 0; t < 4; t++) begin rx_thresh = 2'(t); tick(); end
    for (int i = 0; i < 5; i++) begin rx_pop = 1; tick(); end

    // Master timeout at exactly 64 idle edges (R5)
    rx_push = 1; rx_wdata = 8'hA5; tick();
    idle_n(63);
    chk(tmo_flag == 0, "R5", "tmo before limit", tmo_flag, 0);
    tick();
    chk(tmo_flag == 1, "R5", "tmo at limit", tmo_flag, 1);
    irq_en = 5'b01000; tick();
    flag_clr = 3'b010; rx_pop = 1; tick();
    irq_en = 5'b11111;

    // Pop restarts the count (R6)
    rx_push = 1; rx_wdata = 8'h3C; tick();
    rx_push = 1; rx_wdata = 8'h3D; tick();
    idle_n(40);
    rx_pop = 1; tick();
    idle_n(60);
    chk(tmo_flag == 0, "R6", "restart after pop", tmo_flag, 0);
    idle_n(6);
    rx_pop = 1; tick();
    flag_clr = 3'b010; tick();

    // Slave timeout 576 (R6)
    slave_mode = 1;
    rx_push = 1; rx_wdata = 8'h77; tick();
    idle_n(575);
    chk(tmo_flag == 0, "R6", "slave before limit", tmo_flag, 0);
    tick();
    chk(tmo_flag == 1, "R6", "slave at limit", tmo_flag, 1);
    flag_clr = 3'b010; tick();

    // Slave overrun; push with pop on full queue (R4)
    for (int i = 0; i < 3; i++) begin rx_push = 1; rx_wdata = 8'h20 + 8'(i); tick(); end
    rx_push = 1; rx_pop = 1; rx_wdata = 8'hEE; tick();
    chk(ovr_flag == 1 && rx_count == 3, "R4", "overrun with pop", rx_count, 3);
    flag_clr = 3'b001; tick();
    rx_push = 1; rx_wdata = 8'h24; tick();
    // Set and clear in the same cycle: set wins (R10)
    rx_push = 1; flag_clr = 3'b001; rx_wdata = 8'hEF; tick();
    chk(ovr_flag == 1, "R10", "set beats clear", ovr_flag, 1);
    flag_clr = 3'b001; tick();
    chk(ovr_flag == 0, "R10", "w1c", ovr_flag, 0);
    for (int i = 0; i < 5; i++) begin rx_pop = 1; tick(); end

    // Transmit queue and threshold sweep (R7)
    for (int t = 0; t < 4; t++) begin
      tx_thresh = 2'(t);
      for (int i = 0; i < 5; i++) begin tx_push = 1; tx_wdata = 8'h40 + 8'(4*t + i); tick(); end
      for (int i = 0; i < 5; i++) begin tx_pop = 1; tick(); end
    end
    tx_push = 1; tx_pop = 1; tx_wdata = 8'h55; tick();

    // Underrun posted only at slave select release (R9)
    ss_active = 1; tick();
    tx_underflow = 1; tick();
    idle_n(3);
    chk(udr_flag == 0, "R9", "held while active", udr_flag, 0);
    ss_active = 0; tick();
    chk(udr_flag == 1, "R9", "posted at release", udr_flag, 1);
    flag_clr = 3'b100; tick();
    ss_active = 1; tick(); ss_active = 0; tick();
    chk(udr_flag == 0, "R9", "no pending", udr_flag, 0);
    slave_mode = 0; ss_active = 1; tx_underflow = 1; tick();
    ss_active = 0; tick();
    chk(udr_flag == 0, "R9", "master ignored", udr_flag, 0);

    // Enable sweep (R11)
    for (int e = 0; e < 5; e++) begin irq_en = 5'(1 << e); tick(); end
    irq_en = '0; tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule